// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters. A host reaches them through a byte-wide bus with four addresses. Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2. Address 3 is a control port that can only be written.

A control byte chooses one counter and sets three things for it: how count bytes are transferred, the operating mode, and binary or BCD counting. The host then writes the initial count through that counter's data port, using the chosen byte order.

Each counter has three signals of its own:
- a count-enable tick, synchronous to the block clock, which stands in for the counter's clock input;
- a gate;
- an output.

Three waveforms are supported:
- an output that rises at terminal count, usable as an interrupt request;
- a periodic one-tick low pulse, as a rate generator;
- a square wave.

Control byte layout:
- bits 7:6 select the counter;
- bits 5:4 set the byte access order;
- bits 3:1 set the mode;
- bit 0 selects BCD counting.

Top module: `pit_timer`

## Requirements
- R1: Control bits 7:6 select the counter: 00 selects counter 0, 01 selects counter 1 and 10 selects counter 2. The value 11 changes no counter, and a control write leaves the unselected counters unaffected.
- R2: The control port at address 3 is write-only. A read at address 3 returns 8'h00.
- R3: Control bits 5:4 set the access order, for writes and for reads of the current count at the data port:
  - 01 transfers the low byte only, and the high byte is loaded as zero;
  - 10 transfers the high byte only, and the low byte is loaded as zero;
  - 11 transfers the low byte first and then the high byte;
  - 00 is ignored, and the control write has no effect on the selected counter.
- R4: Control bit 0 chooses the counting code: 0 counts in plain binary, and 1 counts in four BCD digits (for example, 16'h0100 decrements to 16'h0099).
- R5: A loaded count of zero stands for the largest count. Its first decrement gives 16'hFFFF in binary and 16'h9999 in BCD.
- R6: A counter decrements only on a cycle where its tick and its gate are both high. Counting starts with the cycle after the last count byte is written.
- R7: A control write to a counter stops that counter. It sets the output low for mode 0 and high for modes 2 and 3. Loading a count restarts the counter with its output at that same level.
- R8: Mode 0, count N: the output stays low for the first N-1 counting ticks, goes high on the Nth tick and stays high until the counter is reprogrammed.
- R9: Mode 2, count N of at least 2: the output is high for N-1 ticks and low for one tick. The count then reloads and the pattern repeats.
- R10: Mode 3, count N: for an even N of at least 2, the output is high for N/2 ticks and low for N/2 ticks. For an odd N of at least 3, the output is high for (N+1)/2 ticks and low for (N-1)/2 ticks.
- R11: Mode codes in bits 3:1 map as follows: 010 or 110 selects mode 2, 011 or 111 selects mode 3, and every other code is treated as mode 0.
- R12: After reset all outputs are low and every counter is idle until it is programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one byte |
| bus_re | input | 1 | Read strobe for one byte |
| bus_addr | input | 2 | Address: 0 to 2 for counter data, 3 for control |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid in the same cycle as the address |
| cnt_tick | input | 3 | Per-counter count-enable tick |
| cnt_gate | input | 3 | Per-counter gate, high enables counting |
| cnt_out | output | 3 | Per-counter output |

## Verification
The assertions check the following on every cycle:
- a counter whose gate is low keeps its count;
- an output changes only on a counting tick or a write to that counter;
- at most one counter takes a control or data write;
- the control address always reads as zero.

The waveform shapes of modes 0, 2 and 3 can only be shown by the bench's scenarios, which compare every tick against a model of the requirements. The same holds for the odd and even square-wave rules, the byte orders, the zero-as-maximum count, BCD wrap-around and the effect of ignored control words.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NUM_CH = 3;
    localparam int ADDR_W = 2;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        MODE_TC     = 2'd0,
        MODE_RATE   = 2'd1,
        MODE_SQUARE = 2'd2
    } pit_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_BOTH = 2'd3
    } pit_acc_e;

    typedef struct packed {
        pit_mode_e          mode;
        pit_acc_e           acc;
        logic               bcd;
        logic [CNT_W-1:0]   count;
        logic [CNT_W-1:0]   reload;
        logic [BYTE_W-1:0]  lo_hold;
        logic               wr_hi;
        logic               rd_hi;
        logic               run;
        logic               out;
    } chan_t;

    function automatic pit_mode_e decode_mode(input logic [2:0] code);
        pit_mode_e m;
        case (code)
            3'b010, 3'b110: m = MODE_RATE;
            3'b011, 3'b111: m = MODE_SQUARE;
            default:        m = MODE_TC;
        endcase
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] bcd_dec1(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic             borrow;
        logic [3:0]       dig;
        r      = v;
        borrow = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            dig = v[4*d +: 4];
            if (borrow) begin
                if (dig == 4'd0) begin
                    r[4*d +: 4] = 4'd9;
                end else begin
                    r[4*d +: 4] = dig - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] dec_by(input logic [CNT_W-1:0] v,
                                                 input logic [1:0]       k,
                                                 input logic             bcd);
        logic [CNT_W-1:0] r;
        r = v;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(k)) begin
                r = bcd ? bcd_dec1(r) : (r - 1'b1);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
    import pit_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        sel_field,
    output logic [CH-1:0]     ctrl_we,
    output logic [CH-1:0]     data_we,
    output logic [CH-1:0]     rd_pop
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CH);

    logic ctrl_hit;
    assign ctrl_hit = bus_we && (bus_addr == CTRL_ADDR);

    for (genvar i = 0; i < CH; i++) begin : g_dec
        assign ctrl_we[i] = ctrl_hit && (sel_field == 2'(i));
        assign data_we[i] = bus_we && (bus_addr == ADDR_W'(i));
        assign rd_pop[i]  = bus_re && (bus_addr == ADDR_W'(i));
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [5:0]        ctrl_word,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              rd_pop,
    input  logic              tick,
    input  logic              gate,
    output logic              out,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rd_byte
);
    chan_t q, d;

    pit_acc_e         ctrl_acc;
    logic             load;
    logic [CNT_W-1:0] new_val;
    logic [1:0]       step;

    assign ctrl_acc = pit_acc_e'(ctrl_word[5:4]);

    always_comb begin
        d       = q;
        load    = 1'b0;
        new_val = q.reload;
        step    = 2'd2;

        if (rd_pop && q.acc == ACC_BOTH) begin
            d.rd_hi = !q.rd_hi;
        end

        if (ctrl_we) begin
            if (ctrl_acc != ACC_NONE) begin
                d.mode  = decode_mode(ctrl_word[3:1]);
                d.acc   = ctrl_acc;
                d.bcd   = ctrl_word[0];
                d.run   = 1'b0;
                d.wr_hi = 1'b0;
                d.rd_hi = 1'b0;
                d.out   = (decode_mode(ctrl_word[3:1]) != MODE_TC);
            end
        end else if (data_we) begin
            case (q.acc)
                ACC_LO: begin
                    new_val = {{(CNT_W-BYTE_W){1'b0}}, data_byte};
                    load    = 1'b1;
                end
                ACC_HI: begin
                    new_val = {data_byte, {(CNT_W-BYTE_W){1'b0}}};
                    load    = 1'b1;
                end
                ACC_BOTH: begin
                    if (!q.wr_hi) begin
                        d.lo_hold = data_byte;
                        d.wr_hi   = 1'b1;
                    end else begin
                        new_val = {data_byte, q.lo_hold};
                        d.wr_hi = 1'b0;
                        load    = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (q.run && tick && gate) begin
            case (q.mode)
                MODE_RATE: begin
                    if (q.count == CNT_W'(1)) begin
                        d.count = q.reload;
                        d.out   = 1'b1;
                    end else begin
                        d.count = dec_by(q.count, 2'd1, q.bcd);
                        if (q.count == CNT_W'(2)) begin
                            d.out = 1'b0;
                        end
                    end
                end
                MODE_SQUARE: begin
                    if (q.count[0]) begin
                        step = q.out ? 2'd1 : 2'd3;
                    end
                    if (q.count == CNT_W'(step)) begin
                        d.count = q.reload;
                        d.out   = !q.out;
                    end else begin
                        d.count = dec_by(q.count, step, q.bcd);
                    end
                end
                default: begin
                    d.count = dec_by(q.count, 2'd1, q.bcd);
                    if (q.count == CNT_W'(1)) begin
                        d.out = 1'b1;
                    end
                end
            endcase
        end

        if (load) begin
            d.reload = new_val;
            d.count  = new_val;
            d.run    = 1'b1;
            d.out    = (q.mode != MODE_TC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out     = q.out;
    assign count   = q.count;
    assign rd_byte = (q.acc == ACC_HI || (q.acc == ACC_BOTH && q.rd_hi))
                     ? q.count[CNT_W-1 -: BYTE_W] : q.count[BYTE_W-1:0];
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CH-1:0]     cnt_tick,
    input  logic [CH-1:0]     cnt_gate,
    output logic [CH-1:0]     cnt_out
);
    logic [CH-1:0]     ctrl_we;
    logic [CH-1:0]     data_we;
    logic [CH-1:0]     rd_pop;
    logic [CNT_W-1:0]  cnt_val [CH];
    logic [BYTE_W-1:0] rd_byte [CH];

    pit_bus_decode #(.CH(CH)) i_decode (
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .sel_field (bus_wdata[7:6]),
        .ctrl_we   (ctrl_we),
        .data_we   (data_we),
        .rd_pop    (rd_pop)
    );

    for (genvar i = 0; i < CH; i++) begin : g_ch
        pit_counter i_counter (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_we   (ctrl_we[i]),
            .ctrl_word (bus_wdata[5:0]),
            .data_we   (data_we[i]),
            .data_byte (bus_wdata),
            .rd_pop    (rd_pop[i]),
            .tick      (cnt_tick[i]),
            .gate      (cnt_gate[i]),
            .out       (cnt_out[i]),
            .count     (cnt_val[i]),
            .rd_byte   (rd_byte[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < CH; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                bus_rdata = rd_byte[i];
            end
        end
    end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [CH-1:0]     cnt_tick,
    input logic [CH-1:0]     cnt_gate,
    input logic [CH-1:0]     cnt_out,
    input logic [CH-1:0]     ctrl_we,
    input logic [CH-1:0]     data_we,
    input logic [CNT_W-1:0]  cnt_val [CH]
);
    // R2
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(CH)) |-> (bus_rdata == '0));

    // R1
    ctrl_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_we));

    // R1
    data_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_we));

    for (genvar i = 0; i < CH; i++) begin : g_chk
        // R6
        gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_gate[i] && !ctrl_we[i] && !data_we[i]) |=> $stable(cnt_val[i]));

        // R6
        out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(cnt_tick[i] && cnt_gate[i]) && !ctrl_we[i] && !data_we[i])
            |=> $stable(cnt_out[i]));
    end
endmodule

bind pit_timer pit_timer_chk #(.CH(CH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cnt_tick  (cnt_tick),
    .cnt_gate  (cnt_gate),
    .cnt_out   (cnt_out),
    .ctrl_we   (ctrl_we),
    .data_we   (data_we),
    .cnt_val   (cnt_val)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] cnt_tick = '0;
    logic [2:0] cnt_gate = 3'b111;
    logic [2:0] cnt_out;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    typedef struct {
        int    ch;
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #5 clk = ~clk;

    pit_timer i_pit_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_tick  (cnt_tick),
        .cnt_gate  (cnt_gate),
        .cnt_out   (cnt_out)
    );

    // Monitor: compare queued output expectations after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                tests++;
                if (cnt_out[it.ch] !== it.exp) begin
                    fails++;
                    $display("FAIL %s: ch%0d out got %b expected %b",
                             it.tag, it.ch, cnt_out[it.ch], it.exp);
                end
            end
        end
    end

    function automatic logic [7:0] cw(input int sc, input int rl, input int m, input int bcd);
        return {2'(sc), 2'(rl), 3'(m), 1'(bcd)};
    endfunction

    function automatic logic model_out(input int mode, input int n, input int k);
        if (mode == 0) return (k >= n);
        if (mode == 2) return ((k % n) != (n - 1));
        return ((k % n) < ((n + 1) / 2));
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = v;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_re   = 1'b1;
        bus_addr = a;
        #1;
        tests++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s: read addr %0d got %h expected %h", tag, a, bus_rdata, exp);
        end
        @(posedge clk);
        #1;
        bus_re = 1'b0;
    endtask

    task automatic tick(input int ch, input logic exp, input string tag);
        @(negedge clk);
        cnt_tick[ch] = 1'b1;
        sb.push_back('{ch: ch, exp: exp, tag: tag});
        @(posedge clk);
        #1;
        cnt_tick = '0;
    endtask

    task automatic expect_now(input int ch, input logic exp, input string tag);
        @(negedge clk);
        sb.push_back('{ch: ch, exp: exp, tag: tag});
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12: reset state
        for (int c = 0; c < 3; c++) expect_now(c, 1'b0, "R12");
        // R2: control address reads zero
        rd(2'd3, 8'h00, "R2");

        // R8: mode 0, N=5, two-byte load; R7 initial level
        wr(2'd3, cw(0, 3, 0, 0));
        expect_now(0, 1'b0, "R7");
        wr(2'd0, 8'd5);
        wr(2'd0, 8'd0);
        for (int k = 1; k <= 7; k++) tick(0, model_out(0, 5, k), "R8");

        // R1 / R9: program counter 1 in mode 2, counter 0 unaffected
        wr(2'd3, cw(1, 3, 2, 0));
        expect_now(1, 1'b1, "R7");
        expect_now(0, 1'b1, "R1");
        wr(2'd1, 8'd4);
        wr(2'd1, 8'd0);
        for (int k = 1; k <= 10; k++) tick(1, model_out(2, 4, k), "R9");
        expect_now(0, 1'b1, "R1");

        // R10: mode 3, even then odd count
        wr(2'd3, cw(2, 3, 3, 0));
        wr(2'd2, 8'd6);
        wr(2'd2, 8'd0);
        for (int k = 1; k <= 14; k++) tick(2, model_out(3, 6, k), "R10");
        wr(2'd3, cw(2, 3, 3, 0));
        wr(2'd2, 8'd5);
        wr(2'd2, 8'd0);
        for (int k = 1; k <= 12; k++) tick(2, model_out(3, 5, k), "R10");

        // R11: unsupported code 001 acts as mode 0, code 110 acts as mode 2
        wr(2'd3, cw(0, 3, 1, 0));
        expect_now(0, 1'b0, "R11");
        wr(2'd0, 8'd2);
        wr(2'd0, 8'd0);
        for (int k = 1; k <= 3; k++) tick(0, model_out(0, 2, k), "R11");
        wr(2'd3, cw(1, 3, 6, 0));
        wr(2'd1, 8'd3);
        wr(2'd1, 8'd0);
        for (int k = 1; k <= 6; k++) tick(1, model_out(2, 3, k), "R11");

        // R3: low-byte-only access
        wr(2'd3, cw(0, 1, 0, 0));
        wr(2'd0, 8'd3);
        rd(2'd0, 8'h03, "R3");
        rd(2'd0, 8'h03, "R3");
        for (int k = 1; k <= 3; k++) tick(0, model_out(0, 3, k), "R3");
        // R3: high-byte-only access
        wr(2'd3, cw(0, 2, 0, 0));
        wr(2'd0, 8'h01);
        rd(2'd0, 8'h01, "R3");
        tick(0, 1'b0, "R3");
        rd(2'd0, 8'h00, "R3");

        // R6: gate low holds the count
        wr(2'd3, cw(0, 3, 0, 0));
        wr(2'd0, 8'h34);
        wr(2'd0, 8'h12);
        rd(2'd0, 8'h34, "R3");
        rd(2'd0, 8'h12, "R3");
        cnt_gate[0] = 1'b0;
        for (int k = 0; k < 5; k++) tick(0, 1'b0, "R6");
        rd(2'd0, 8'h34, "R6");
        rd(2'd0, 8'h12, "R6");
        cnt_gate[0] = 1'b1;
        tick(0, 1'b0, "R6");
        rd(2'd0, 8'h33, "R6");
        rd(2'd0, 8'h12, "R6");

        // R3: access code 00 is ignored
        wr(2'd3, cw(0, 0, 2, 0));
        expect_now(0, 1'b0, "R3");
        rd(2'd0, 8'h33, "R3");
        rd(2'd0, 8'h12, "R3");

        // R1: select code 11 changes no counter
        wr(2'd3, cw(3, 3, 2, 0));
        expect_now(0, 1'b0, "R1");
        expect_now(1, model_out(2, 3, 6), "R1");
        expect_now(2, model_out(3, 5, 12), "R1");
        rd(2'd0, 8'h33, "R1");

        // R5: zero is the largest count, binary and BCD
        wr(2'd3, cw(0, 3, 0, 0));
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        tick(0, 1'b0, "R5");
        rd(2'd0, 8'hFF, "R5");
        rd(2'd0, 8'hFF, "R5");
        wr(2'd3, cw(0, 3, 0, 1));
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        tick(0, 1'b0, "R5");
        rd(2'd0, 8'h99, "R5");
        rd(2'd0, 8'h99, "R5");

        // R4: BCD borrow across digits and BCD period
        wr(2'd3, cw(0, 3, 0, 1));
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        tick(0, 1'b0, "R4");
        rd(2'd0, 8'h99, "R4");
        rd(2'd0, 8'h00, "R4");
        wr(2'd3, cw(1, 3, 2, 1));
        wr(2'd1, 8'h10);
        wr(2'd1, 8'h00);
        for (int k = 1; k <= 12; k++) tick(1, model_out(2, 10, k), "R4");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule